// File: doc/BRIEF.md
# UART Host Register and Command Controller

This block is the register-side front end of one UART channel. A byte-wide host bus reaches the channel's mode, status, command, data, interrupt and baud-divider registers. The block decodes the bus accesses, keeps the transmitter's enable, empty and ready state, and passes each transmit byte onward as a one-cycle valid strobe. It also forms the interrupt status from live channel flags and drives one registered interrupt line through a mask.

The receive FIFO is a separate block. It supplies its ready flag, its full flag and its head byte to this controller. In return it receives a pop strobe on each data read, a flush strobe on each receiver reset, and the receiver enable. A break event from the line side sets a sticky change flag. One command byte carries three separate fields (miscellaneous, transmitter, receiver), and all three act in the same write. One address reaches two mode registers through a pointer that advances on its own.

Top module: `uart_regs_ctrl`

## Requirements
- R1: After reset the status register reads 0x08, both mode registers, the interrupt status and the interrupt mask read 0, the transmitter and receiver are disabled, and irq_o is low.
- R2: Only address bits [5:0] are decoded, so an address with higher bits set aliases its low-6-bit offset. Reads of offsets 0x08, 0x10 and any unmapped offset return 0. Writes to status (0x04) and to unmapped offsets change nothing.
- R3: Offset 0x00 reads and writes the mode register chosen by a 1-bit pointer (0 = first, 1 = second). Every write there then moves the pointer to the second. The miscellaneous command code 1 returns the pointer to the first.
- R4: Status (0x04) holds the receive-ready input at bit 0, the receive-full input at bit 1, transmitter-ready at bit 2 and transmitter-empty at bit 3. Bits 7:4 read 0.
- R5: A write to offset 0x0C while the transmitter is enabled puts the byte on tx_data_o with exactly one tx_valid_o pulse in the cycle after the write, and transmitter-empty stays set.
- R6: A write to offset 0x0C while the transmitter is disabled clears transmitter-empty and gives no pulse. A later enable sends the held byte once and sets transmitter-empty again.
- R7: Command bits [3:2] drive the transmitter: 1 enables it, 2 disables it, and 0 and 3 leave it as it is. Transmitter-ready always equals the enable.
- R8: Miscellaneous code 3 (command bits [6:4]) resets the transmitter. It clears the enable, sets transmitter-empty so that a held byte is dropped, and produces no pulse.
- R9: Command bits [1:0] drive rx_en_o with the same encoding as R7. Miscellaneous code 2 clears rx_en_o and pulses rx_flush_o during the command write. The receiver field acts after the miscellaneous field.
- R10: Interrupt status (0x14) bit 0 equals transmitter-ready. Bit 1 equals receive-full when bit 6 of the first mode register is set, and receive-ready otherwise. Bit 2 is set by break_i and cleared by miscellaneous code 5. Codes 4, 6 and 7 have no effect.
- R11: irq_o is registered. It goes high one cycle after any interrupt status bit is set under a set mask bit (mask written at 0x14), and it falls one cycle after that condition ends.
- R12: A read of offset 0x0C returns rx_data_i and pulses rx_pop_o when receive-ready is set. Otherwise it returns 0 and gives no pop.
- R13: Offsets 0x18 and 0x1C read the parameters DIV_MSB and DIV_LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_en_i is high |
| rx_rdy_i | input | 1 | Receive FIFO holds at least one byte |
| rx_full_i | input | 1 | Receive FIFO is full |
| rx_data_i | input | 8 | Receive FIFO head byte |
| break_i | input | 1 | Break-change event pulse |
| rx_pop_o | output | 1 | Pop the receive FIFO head |
| rx_flush_o | output | 1 | Empty the receive FIFO |
| rx_en_o | output | 1 | Receiver enable |
| tx_data_o | output | 8 | Transmit byte |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a transmit byte held while the transmitter is off, because it needs the disable, the buffer write and the release to come in order. The bench disables the transmitter, writes a byte and watches transmitter-empty clear with no strobe. It then either enables the transmitter, which must give exactly one strobe with the held byte, or first issues a transmitter reset, after which an enable must give no strobe. The receive-interrupt source switch is reached by rewinding the mode pointer and writing bit 6 of the first mode register while the full and ready inputs differ.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int unsigned OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_MODE    = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT    = 6'h04;
  localparam logic [OFF_W-1:0] OFF_CMD     = 6'h08;
  localparam logic [OFF_W-1:0] OFF_DATA    = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_INT     = 6'h14;
  localparam logic [OFF_W-1:0] OFF_DIV_MSB = 6'h18;
  localparam logic [OFF_W-1:0] OFF_DIV_LSB = 6'h1C;

  localparam int unsigned RX_SRC_BIT = 6;

  typedef enum logic [2:0] {
    MISC_NOP, MISC_PTR_RST, MISC_RX_RST, MISC_TX_RST,
    MISC_ERR_RST, MISC_BRK_CLR, MISC_BRK_ON, MISC_BRK_OFF
  } misc_e;

  typedef enum logic [1:0] {DIR_NOP, DIR_EN, DIR_DIS, DIR_RSV} dir_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    dir_e tx_op;
    dir_e rx_op;
  } cmd_t;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_regs_pkg::*;
(
  input  logic       cmd_wr_i,
  input  logic [7:0] cmd_i,
  output cmd_t       cmd_o
);
  misc_e misc;
  assign misc = misc_e'(cmd_i[6:4]);

  always_comb begin
    cmd_o = '0;
    if (cmd_wr_i) begin
      cmd_o.ptr_rst = (misc == MISC_PTR_RST);
      cmd_o.rx_rst  = (misc == MISC_RX_RST);
      cmd_o.tx_rst  = (misc == MISC_TX_RST);
      cmd_o.brk_clr = (misc == MISC_BRK_CLR);
      cmd_o.tx_op   = dir_e'(cmd_i[3:2]);
      cmd_o.rx_op   = dir_e'(cmd_i[1:0]);
    end
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_rst_i,
  input  dir_e              tx_op_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              tx_en_o,
  output logic              tx_emp_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o
);
  logic en_n, emp_n, issue;

  // misc field first, then transmitter field, then release of a held byte
  always_comb begin
    en_n  = tx_en_o;
    emp_n = tx_emp_o;
    issue = 1'b0;
    if (tx_rst_i) begin
      en_n  = 1'b0;
      emp_n = 1'b1;
    end
    if (tx_op_i == DIR_EN)       en_n = 1'b1;
    else if (tx_op_i == DIR_DIS) en_n = 1'b0;
    if (buf_wr_i) emp_n = 1'b0;
    if (en_n && !emp_n) begin
      issue = 1'b1;
      emp_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_o    <= 1'b0;
      tx_emp_o   <= 1'b1;
      tx_data_o  <= '0;
      tx_valid_o <= 1'b0;
    end else begin
      tx_en_o    <= en_n;
      tx_emp_o   <= emp_n;
      tx_valid_o <= issue;
      if (buf_wr_i) tx_data_o <= wdata_i;
    end
  end

  p_valid_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_en_o);
  p_valid_emp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_emp_o);
  p_tx_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_rst_i && tx_op_i != DIR_EN) |=> (!tx_en_o && tx_emp_o && !tx_valid_o));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_rdy_i,
  input  logic              rx_rdy_i,
  input  logic              rx_full_i,
  input  logic              rx_src_full_i,
  input  logic              brk_set_i,
  input  logic              brk_clr_i,
  input  logic              imr_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] isr_o,
  output logic [DATA_W-1:0] imr_o,
  output logic              irq_o
);
  logic brk_q;

  always_comb begin
    isr_o    = '0;
    isr_o[0] = tx_rdy_i;
    isr_o[1] = rx_src_full_i ? rx_full_i : rx_rdy_i;
    isr_o[2] = brk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q <= 1'b0;
      imr_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (brk_set_i)      brk_q <= 1'b1;
      else if (brk_clr_i) brk_q <= 1'b0;
      if (imr_wr_i) imr_o <= wdata_i;
      irq_o <= |(isr_o & imr_o);
    end
  end

  p_brk_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_clr_i && !brk_set_i) |=> !brk_q);
  p_irq_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_o == '0) |=> !irq_o);
endmodule

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [7:0]  DIV_MSB = 8'h00,
  parameter logic [7:0]  DIV_LSB = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rx_rdy_i,
  input  logic              rx_full_i,
  input  logic [7:0]        rx_data_i,
  input  logic              break_i,
  output logic              rx_pop_o,
  output logic              rx_flush_o,
  output logic              rx_en_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              irq_o
);
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_MODE = 2;

  logic [OFF_W-1:0]  off;
  logic              wr_mode, wr_cmd, wr_data, wr_int, rd_data;
  cmd_t              cmd;
  logic [DATA_W-1:0] mode_q [N_MODE];
  logic              mode_ptr_q;
  logic              tx_en, tx_emp;
  logic [DATA_W-1:0] isr, imr, status, rmux;

  assign off     = addr_i[OFF_W-1:0];
  assign wr_mode = wr_en_i && off == OFF_MODE;
  assign wr_cmd  = wr_en_i && off == OFF_CMD;
  assign wr_data = wr_en_i && off == OFF_DATA;
  assign wr_int  = wr_en_i && off == OFF_INT;
  assign rd_data = rd_en_i && off == OFF_DATA;

  uart_cmd_decode i_cmd (
    .cmd_wr_i (wr_cmd),
    .cmd_i    (wdata_i),
    .cmd_o    (cmd)
  );

  uart_tx_ctrl #(.DATA_W(DATA_W)) i_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_rst_i   (cmd.tx_rst),
    .tx_op_i    (cmd.tx_op),
    .buf_wr_i   (wr_data),
    .wdata_i    (wdata_i),
    .tx_en_o    (tx_en),
    .tx_emp_o   (tx_emp),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o)
  );

  uart_irq_ctrl #(.DATA_W(DATA_W)) i_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_rdy_i      (tx_en),
    .rx_rdy_i      (rx_rdy_i),
    .rx_full_i     (rx_full_i),
    .rx_src_full_i (mode_q[0][RX_SRC_BIT]),
    .brk_set_i     (break_i),
    .brk_clr_i     (cmd.brk_clr),
    .imr_wr_i      (wr_int),
    .wdata_i       (wdata_i),
    .isr_o         (isr),
    .imr_o         (imr),
    .irq_o         (irq_o)
  );

  // mode registers behind one auto-advancing pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_ptr_q <= 1'b0;
      for (int i = 0; i < N_MODE; i++) mode_q[i] <= '0;
    end else if (wr_mode) begin
      mode_q[mode_ptr_q] <= wdata_i;
      mode_ptr_q         <= 1'b1;
    end else if (cmd.ptr_rst) begin
      mode_ptr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_o <= 1'b0;
    end else if (wr_cmd) begin
      if (cmd.rx_op == DIR_EN)                      rx_en_o <= 1'b1;
      else if (cmd.rx_op == DIR_DIS || cmd.rx_rst)  rx_en_o <= 1'b0;
    end
  end

  assign rx_flush_o = cmd.rx_rst;
  assign rx_pop_o   = rd_data && rx_rdy_i;
  assign status     = {4'b0, tx_emp, tx_en, rx_full_i, rx_rdy_i};

  always_comb begin
    unique case (off)
      OFF_MODE:    rmux = mode_q[mode_ptr_q];
      OFF_STAT:    rmux = status;
      OFF_DATA:    rmux = rx_rdy_i ? rx_data_i : '0;
      OFF_INT:     rmux = isr;
      OFF_DIV_MSB: rmux = DIV_MSB;
      OFF_DIV_LSB: rmux = DIV_LSB;
      default:     rmux = '0;
    endcase
  end
  assign rdata_o = rd_en_i ? rmux : '0;

  p_ptr_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> mode_ptr_q);
  p_pop_gated_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (rx_rdy_i && rd_en_i));
  p_flush_disables_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flush_o && cmd.rx_op != DIR_EN) |=> !rx_en_o);
  p_txrdy_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && cmd.tx_op == DIR_DIS) |=> !isr[0]);
endmodule

// File: tb/test_uart_regs_ctrl.sv
module test_uart_regs_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_rdy = 1'b0, rx_full = 1'b0;
  logic [7:0] rx_data = '0;
  logic       brk = 1'b0;
  logic       rx_pop, rx_flush, rx_en, tx_valid, irq;
  logic [7:0] tx_data;

  int n_chk = 0, n_bad = 0, n_pulse = 0;
  logic flush_seen;
  logic [7:0] rd_val;
  logic pop_val;

  always #2 clk = ~clk;

  uart_regs_ctrl #(.ADDR_W(8), .DIV_MSB(8'h01), .DIV_LSB(8'hA2)) i_uart_regs_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .rx_rdy_i(rx_rdy), .rx_full_i(rx_full),
    .rx_data_i(rx_data), .break_i(brk), .rx_pop_o(rx_pop), .rx_flush_o(rx_flush),
    .rx_en_o(rx_en), .tx_data_o(tx_data), .tx_valid_o(tx_valid), .irq_o(irq)
  );

  always @(negedge clk) if (tx_valid) n_pulse++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #1 flush_seen = rx_flush;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 rd_val = rdata; pop_val = rx_pop;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    rd(8'h04); check("R1 status", rd_val, 8'h08);
    rd(8'h00); check("R1 mode", rd_val, 8'h00);
    rd(8'h14); check("R1 isr", rd_val, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 rx_en", {7'b0, rx_en}, 8'h00);
  endtask

  task automatic t_mode;
    wr(8'h00, 8'hA5);
    wr(8'h00, 8'h3C);
    rd(8'h00); check("R3 second mode reg", rd_val, 8'h3C);
    wr(8'h08, 8'h10);
    rd(8'h00); check("R3 pointer rewound", rd_val, 8'hA5);
    rd(8'hC0); check("R2 alias of 0x00", rd_val, 8'hA5);
  endtask

  task automatic t_unmapped;
    rd(8'h08); check("R2 cmd reads zero", rd_val, 8'h00);
    rd(8'h10); check("R2 0x10 reads zero", rd_val, 8'h00);
    rd(8'h20); check("R2 unmapped reads zero", rd_val, 8'h00);
    wr(8'h04, 8'hFF);
    wr(8'h24, 8'hFF);
    rd(8'h04); check("R2 status write ignored", rd_val, 8'h08);
    rd(8'h14); check("R2 unmapped write ignored", rd_val, 8'h00);
  endtask

  task automatic t_tx_enabled;
    int p0;
    wr(8'h08, 8'h04);
    rd(8'h04); check("R7 enable sets TxRDY", rd_val, 8'h0C);
    p0 = n_pulse;
    wr(8'h4C, 8'h5A);
    check("R5 valid after write", {7'b0, tx_valid}, 8'h01);
    check("R5 byte", tx_data, 8'h5A);
    repeat (3) @(negedge clk);
    check("R5 one pulse", 8'(n_pulse - p0), 8'h01);
    rd(8'h04); check("R5 TxEMP kept", rd_val, 8'h0C);
  endtask

  task automatic t_tx_held;
    int p0;
    wr(8'h08, 8'h08);
    rd(8'h04); check("R7 disable clears TxRDY", rd_val, 8'h08);
    p0 = n_pulse;
    wr(8'h0C, 8'h33);
    rd(8'h04); check("R6 TxEMP cleared", rd_val, 8'h00);
    wr(8'h08, 8'h0C);
    rd(8'h04); check("R7 reserved ignored", rd_val, 8'h00);
    check("R6 no pulse while off", 8'(n_pulse - p0), 8'h00);
    wr(8'h08, 8'h04);
    check("R6 release pulse", {7'b0, tx_valid}, 8'h01);
    check("R6 held byte", tx_data, 8'h33);
    repeat (2) @(negedge clk);
    check("R6 one release", 8'(n_pulse - p0), 8'h01);
    rd(8'h04); check("R6 TxEMP set", rd_val, 8'h0C);
  endtask

  task automatic t_tx_reset;
    int p0;
    wr(8'h08, 8'h08);
    p0 = n_pulse;
    wr(8'h0C, 8'h44);
    wr(8'h08, 8'h30);
    rd(8'h04); check("R8 reset status", rd_val, 8'h08);
    wr(8'h08, 8'h04);
    repeat (2) @(negedge clk);
    check("R8 byte dropped", 8'(n_pulse - p0), 8'h00);
    rd(8'h04); check("R8 re-enabled", rd_val, 8'h0C);
  endtask

  task automatic t_rx_cmd;
    wr(8'h08, 8'h01); check("R9 rx enable", {7'b0, rx_en}, 8'h01);
    wr(8'h08, 8'h03); check("R9 reserved ignored", {7'b0, rx_en}, 8'h01);
    wr(8'h08, 8'h02); check("R9 rx disable", {7'b0, rx_en}, 8'h00);
    wr(8'h08, 8'h01);
    wr(8'h08, 8'h20);
    check("R9 flush pulse", {7'b0, flush_seen}, 8'h01);
    check("R9 reset disables", {7'b0, rx_en}, 8'h00);
    wr(8'h08, 8'h21);
    check("R9 rx field after misc", {7'b0, rx_en}, 8'h01);
  endtask

  task automatic t_isr;
    rx_rdy = 1'b1; rx_full = 1'b0;
    rd(8'h04); check("R4 status layout", rd_val, 8'h0D);
    rd(8'h14); check("R10 rx ready source", rd_val, 8'h03);
    wr(8'h08, 8'h10);
    wr(8'h00, 8'h40);
    rd(8'h14); check("R10 full source", rd_val, 8'h01);
    rx_full = 1'b1;
    rd(8'h14); check("R10 full set", rd_val, 8'h03);
    @(negedge clk); brk = 1'b1;
    @(negedge clk); brk = 1'b0;
    rd(8'h14); check("R10 break set", rd_val, 8'h07);
    wr(8'h08, 8'h40); wr(8'h08, 8'h60); wr(8'h08, 8'h70);
    rd(8'h14); check("R10 codes 4 6 7 no effect", rd_val, 8'h07);
    wr(8'h08, 8'h50);
    rd(8'h14); check("R10 break cleared", rd_val, 8'h03);
    rx_rdy = 1'b0; rx_full = 1'b0;
  endtask

  task automatic t_irq;
    wr(8'h14, 8'h04);
    @(negedge clk); check("R11 masked idle", {7'b0, irq}, 8'h00);
    brk = 1'b1;
    @(negedge clk); brk = 1'b0;
    check("R11 still low same edge", {7'b0, irq}, 8'h00);
    @(negedge clk); check("R11 rises", {7'b0, irq}, 8'h01);
    wr(8'h08, 8'h50);
    check("R11 old value held", {7'b0, irq}, 8'h01);
    @(negedge clk); check("R11 falls", {7'b0, irq}, 8'h00);
    wr(8'h14, 8'h01);
    @(negedge clk); check("R11 TxINT under mask", {7'b0, irq}, 8'h01);
    wr(8'h14, 8'h00);
    @(negedge clk); check("R11 mask cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rxdata;
    rx_rdy = 1'b1; rx_data = 8'h9C;
    rd(8'h0C);
    check("R12 data", rd_val, 8'h9C);
    check("R12 pop", {7'b0, pop_val}, 8'h01);
    rx_rdy = 1'b0;
    rd(8'h0C);
    check("R12 empty reads zero", rd_val, 8'h00);
    check("R12 no pop when empty", {7'b0, pop_val}, 8'h00);
  endtask

  task automatic t_baud;
    rd(8'h18); check("R13 divider msb", rd_val, 8'h01);
    rd(8'h1C); check("R13 divider lsb", rd_val, 8'hA2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode();
    t_unmapped();
    t_tx_enabled();
    t_tx_held();
    t_tx_reset();
    t_rx_cmd();
    t_isr();
    t_irq();
    t_rxdata();
    t_baud();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule